// File: doc/BRIEF.md
# Early-late gate bit synchronizer

This block is a digital phase-locked loop that regenerates a data clock aligned to an incoming serial bit stream. A high-rate sample clock drives all of its logic. A run-time ratio sets how many sample clocks make up one symbol (one bit period). A symbol counter divides each symbol into an early half and a late half, and a separate integrator sums the data samples over each half. At the end of every symbol, the magnitude difference between the two sums is added to a signed phase-error accumulator.

When the accumulated error crosses a programmable threshold, the next symbol is made shorter or longer by a programmable step. The symbol boundary then moves onto the data transitions, and the falling edge of the regenerated clock settles near the middle of each bit. If the data input is driven by a reference clock, the input looks like an alternating bit pattern and the block locks to it as well. The recovered clock then runs at twice the reference frequency.

Top module: `el_gate_sync`

## Requirements
- R1: Reset is asynchronous and active low on `rst_ni`. While it is asserted and just after release, `dclk_o` is 1, the symbol count is 0, and both integrators and the phase error are 0.
- R2: A symbol lasts `ratio_i` sample clocks unless a correction is pending. The count runs 0 to length-1. `dclk_o` is 1 while the count is below `ratio_i`/2 and 0 for the rest of the symbol. `ratio_i` must be even and within 4 to 254.
- R3: Each sample adds +1 (data 1) or -1 (data 0) to the integrator of its half. The last sample of a symbol is included. At the symbol end, |early sum| minus |late sum| is added to the phase error and both integrators clear. Between symbol ends the error holds.
- R4: If the updated error is at least +`thr_i`, the next symbol is `ratio_i`-`step_i` long and the error clears.
- R5: If the updated error is at most -`thr_i`, the next symbol is `ratio_i`+`step_i` long and the error clears.
- R6: For a random data stream whose bit period is `ratio_i` samples, at any starting phase, the falling edge of `dclk_o` settles within `step_i` samples of mid-bit. This assumes `step_i` < `ratio_i`/2 and `thr_i` > 2*`step_i`.
- R7: For an alternating 1010 input with one bit per `ratio_i` samples, `dclk_o` locks with the same mid-bit tolerance.
- R8: Asserting reset in the middle of a symbol forces `dclk_o` to 1 before the next sample-clock edge.
- R9: Operation and lock hold at both ratio limits, 4 and 254.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial data, sampled once per clock |
| ratio_i | input | 8 | Sample clocks per symbol, even, 4..254 |
| thr_i | input | 16 | Phase-error magnitude that triggers a correction |
| step_i | input | 8 | Correction size in sample clocks |
| dclk_o | output | 1 | Regenerated data clock, high in early half |

## Verification
A constant input has no transitions, so both gate sums stay at full magnitude and the error never moves. This isolates the nominal symbol length and the duty of the output clock. A hashed pseudo-random stream started at several phase offsets drives corrections in both directions and shows that lock converges from either side of the boundary. The alternating pattern gives a transition on every bit, which is the reference-clock use. The minimum and maximum ratios probe the counter and accumulator widths at their edges.

// File: rtl/els_pkg.sv
package els_pkg;
  localparam int RATIO_W_D = 8;
  localparam int THR_W_D   = 16;
  localparam int STEP_W_D  = 8;
  localparam int CNT_W_D   = ((RATIO_W_D > STEP_W_D) ? RATIO_W_D : STEP_W_D) + 1;
  localparam int INT_W_D   = CNT_W_D + 1;
  localparam int ERR_W_D   = ((THR_W_D > INT_W_D) ? THR_W_D : INT_W_D) + 2;

  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_SHORT = 2'd1,
    ADJ_LONG  = 2'd2
  } adj_e;
endpackage

// File: rtl/els_symbol_timer.sv
module els_symbol_timer
  import els_pkg::*;
#(
  parameter int RATIO_W = RATIO_W_D,
  parameter int STEP_W  = STEP_W_D,
  parameter int CNT_W   = CNT_W_D
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [STEP_W-1:0]  step_i,
  input  adj_e               adj_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               early_o,
  output logic               sym_end_o
);
  logic [CNT_W-1:0] cnt_q, ratio_x, step_x, half_x, len;
  adj_e             adj_q;

  assign ratio_x = {{(CNT_W-RATIO_W){1'b0}}, ratio_i};
  assign step_x  = {{(CNT_W-STEP_W){1'b0}}, step_i};
  assign half_x  = ratio_x >> 1;

  always_comb begin
    unique case (adj_q)
      ADJ_SHORT: len = ratio_x - step_x;
      ADJ_LONG:  len = ratio_x + step_x;
      default:   len = ratio_x;
    endcase
  end

  // >= rather than == keeps the counter bounded if length shrinks under it
  assign sym_end_o = (cnt_q >= len - 1'b1);
  assign early_o   = (cnt_q < half_x);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      adj_q <= ADJ_NONE;
    end else if (sym_end_o) begin
      cnt_q <= '0;
      adj_q <= adj_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/els_gate_integ.sv
module els_gate_integ #(
  parameter int W = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                clr_i,
  input  logic                d_i,
  output logic signed [W-1:0] acc_o
);
  logic signed [W-1:0] acc_q;
  logic signed [W-1:0] one;

  assign one = W'(1);

  // acc_o already includes this cycle's sample
  always_comb begin
    acc_o = acc_q;
    if (en_i) acc_o = d_i ? acc_q + one : acc_q - one;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else             acc_q <= acc_o;
  end
endmodule

// File: rtl/els_phase_acc.sv
module els_phase_acc
  import els_pkg::*;
#(
  parameter int INT_W = INT_W_D,
  parameter int THR_W = THR_W_D,
  parameter int ERR_W = ERR_W_D
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sym_end_i,
  input  logic signed [INT_W-1:0] early_i,
  input  logic signed [INT_W-1:0] late_i,
  input  logic [THR_W-1:0]        thr_i,
  output adj_e                    adj_o,
  output logic signed [ERR_W-1:0] err_o
);
  logic signed [ERR_W-1:0] err_q, e_x, l_x, thr_x, sum;

  function automatic logic signed [ERR_W-1:0] mag(input logic signed [ERR_W-1:0] v);
    return (v < 0) ? -v : v;
  endfunction

  assign e_x   = $signed({{(ERR_W-INT_W){early_i[INT_W-1]}}, early_i});
  assign l_x   = $signed({{(ERR_W-INT_W){late_i[INT_W-1]}}, late_i});
  assign thr_x = $signed({{(ERR_W-THR_W){1'b0}}, thr_i});
  assign sum   = err_q + mag(e_x) - mag(l_x);

  always_comb begin
    if (sum >= thr_x)       adj_o = ADJ_SHORT;
    else if (sum <= -thr_x) adj_o = ADJ_LONG;
    else                    adj_o = ADJ_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= '0;
    else if (sym_end_i) err_q <= (adj_o == ADJ_NONE) ? sum : '0;
  end

  assign err_o = err_q;
endmodule

// File: rtl/el_gate_sync.sv
module el_gate_sync
  import els_pkg::*;
#(
  parameter int RATIO_W = RATIO_W_D,
  parameter int THR_W   = THR_W_D,
  parameter int STEP_W  = STEP_W_D
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               data_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic [THR_W-1:0]   thr_i,
  input  logic [STEP_W-1:0]  step_i,
  output logic               dclk_o
);
  localparam int CNT_W = ((RATIO_W > STEP_W) ? RATIO_W : STEP_W) + 1;
  localparam int INT_W = CNT_W + 1;
  localparam int ERR_W = ((THR_W > INT_W) ? THR_W : INT_W) + 2;

  logic [CNT_W-1:0]        cnt;
  logic                    early, sym_end;
  adj_e                    adj;
  logic signed [ERR_W-1:0] err_q;
  logic signed [INT_W-1:0] gate_acc [2];

  els_symbol_timer #(.RATIO_W(RATIO_W), .STEP_W(STEP_W), .CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .ratio_i, .step_i,
    .adj_i(adj), .cnt_o(cnt), .early_o(early), .sym_end_o(sym_end)
  );

  // index 0: early gate, index 1: late gate
  for (genvar g = 0; g < 2; g++) begin : g_gate
    els_gate_integ #(.W(INT_W)) u_integ (
      .clk_i, .rst_ni,
      .en_i ((g == 0) ? early : !early),
      .clr_i(sym_end),
      .d_i  (data_i),
      .acc_o(gate_acc[g])
    );
  end

  els_phase_acc #(.INT_W(INT_W), .THR_W(THR_W), .ERR_W(ERR_W)) u_acc (
    .clk_i, .rst_ni, .sym_end_i(sym_end),
    .early_i(gate_acc[0]), .late_i(gate_acc[1]),
    .thr_i, .adj_o(adj), .err_o(err_q)
  );

  assign dclk_o = early;
endmodule

// File: rtl/els_sync_chk.sv
module els_sync_chk
  import els_pkg::*;
#(
  parameter int THR_W = THR_W_D,
  parameter int CNT_W = CNT_W_D,
  parameter int ERR_W = ERR_W_D
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [THR_W-1:0]        thr_i,
  input logic [CNT_W-1:0]        cnt_i,
  input logic                    sym_end_i,
  input adj_e                    adj_i,
  input logic signed [ERR_W-1:0] err_i
);
  logic signed [ERR_W-1:0] thr_x;
  assign thr_x = $signed({{(ERR_W-THR_W){1'b0}}, thr_i});

  assert_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_end_i |=> (cnt_i == '0));

  assert_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_end_i |=> (cnt_i == $past(cnt_i) + 1'b1));

  assert_err_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sym_end_i |=> $stable(err_i));

  assert_err_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_end_i && adj_i == ADJ_NONE) |=> (err_i < $past(thr_x)) && (err_i > -$past(thr_x)));

  assert_clear_short_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_end_i && adj_i == ADJ_SHORT) |=> (err_i == '0));

  assert_clear_long_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_end_i && adj_i == ADJ_LONG) |=> (err_i == '0));
endmodule

bind el_gate_sync els_sync_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .thr_i    (thr_i),
  .cnt_i    (cnt),
  .sym_end_i(sym_end),
  .adj_i    (adj),
  .err_i    (err_q)
);

// File: tb/tb_el_gate_sync.sv
module tb_el_gate_sync;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        data = 1'b0;
  logic [7:0]  ratio = 8'd8;
  logic [15:0] thr = 16'd4;
  logic [7:0]  step = 8'd1;
  wire         dclk;

  int total = 0, bad = 0;
  int n_short = 0, n_long = 0;
  bit armed = 0;

  el_gate_sync dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data),
    .ratio_i(ratio), .thr_i(thr), .step_i(step), .dclk_o(dclk)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model: samples queued per window, sums formed only at symbol end
  int m_cnt = 0, m_kind = 0, m_err = 0;
  bit q_e[$], q_l[$];

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int m_len();
    if (m_kind == 1) return int'(ratio) - int'(step);
    if (m_kind == 2) return int'(ratio) + int'(step);
    return int'(ratio);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_kind = 0; m_err = 0;
      q_e.delete(); q_l.delete();
    end else begin
      if (m_cnt < int'(ratio) / 2) q_e.push_back(data);
      else                         q_l.push_back(data);
      if (m_cnt >= m_len() - 1) begin
        int se, sl;
        se = 0; sl = 0;
        foreach (q_e[i]) se += q_e[i] ? 1 : -1;
        foreach (q_l[i]) sl += q_l[i] ? 1 : -1;
        q_e.delete(); q_l.delete();
        m_err += iabs(se) - iabs(sl);
        if (m_err >= int'(thr))       begin m_kind = 1; m_err = 0; n_short++; end
        else if (m_err <= -int'(thr)) begin m_kind = 2; m_err = 0; n_long++;  end
        else                            m_kind = 0;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
  end

  // per-cycle comparison; tag reflects the kind of symbol in progress
  always @(negedge clk) begin
    if (armed) begin
      bit exp_d;
      string tag;
      exp_d = (m_cnt < int'(ratio) / 2);
      tag = (m_kind == 1) ? "R4" : (m_kind == 2) ? "R5" : "R2";
      chk(dclk === exp_d, tag, "R3 model dclk_o", int'(dclk), int'(exp_d));
    end
  end

  // stimulus source and lock measurement
  int  gen_mode = 0, gen_off = 0, t = 0, meas_from = 0;
  int  lock_edges = 0, lock_bad = 0, lock_max = 0;
  bit  prev_d = 1'b1;

  function automatic bit gen_bit(input int idx);
    bit [31:0] h;
    if (gen_mode == 0) return 1'b1;
    if (gen_mode == 2) return idx[0];
    h = idx * 32'h9E37_79B1;
    return h[17];
  endfunction

  always @(negedge clk) begin
    #2;
    if (t >= meas_from && meas_from > 0 && prev_d && !dclk) begin
      int pos, d;
      pos = (t + gen_off) % int'(ratio);
      d = iabs(pos - int'(ratio) / 2);
      lock_edges++;
      if (d > lock_max) lock_max = d;
      if (d > int'(step)) lock_bad++;
    end
    prev_d = dclk;
    data = gen_bit((t + gen_off) / int'(ratio));
    t++;
  end

  task automatic scn_start(input int r, input int th, input int st, input int md, input int off, input int meas);
    @(negedge clk); #1;
    rst_n = 1'b0;
    ratio = 8'(r); thr = 16'(th); step = 8'(st);
    gen_mode = md; gen_off = off; meas_from = 0;
    lock_edges = 0; lock_bad = 0; lock_max = 0;
    repeat (2) @(negedge clk);
    #1;
    chk(dclk === 1'b1, "R1", "dclk_o during reset", int'(dclk), 1);
    rst_n = 1'b1; t = 0; prev_d = 1'b1; armed = 1;
    meas_from = meas;
    chk(dclk === 1'b1, "R1", "dclk_o after release", int'(dclk), 1);
  endtask

  task automatic lock_run(input int ncyc, input string req);
    repeat (ncyc) @(negedge clk);
    #3;
    chk(lock_edges > 0, req, "falling edges seen in window", lock_edges, 1);
    chk(lock_bad == 0, req, "worst |edge-midbit|", lock_max, int'(step));
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R2: constant data, exact nominal duty and period
    scn_start(12, 4, 1, 0, 0, 0);
    begin
      int mism;
      mism = 0;
      for (int i = 1; i <= 36; i++) begin
        @(negedge clk); #1;
        if (dclk !== ((i % 12) < 6)) mism++;
      end
      chk(mism == 0, "R2", "nominal pattern mismatches", mism, 0);
    end

    // R6: random data, phase on late side
    scn_start(16, 6, 2, 1, 5, 3000);
    lock_run(4000, "R6");

    // R8: async reset mid-symbol while dclk_o is low
    begin
      @(negedge clk);
      while (dclk !== 1'b0) @(negedge clk);
      #1; rst_n = 1'b0;
      #1;
      chk(dclk === 1'b1, "R8", "dclk_o right after async reset", int'(dclk), 1);
    end

    // R6: random data, phase on early side
    scn_start(10, 3, 1, 1, 7, 2000);
    lock_run(3000, "R6");

    // R7: alternating pattern
    scn_start(8, 4, 1, 2, 3, 1400);
    lock_run(2000, "R7");

    // R9: minimum ratio
    scn_start(4, 3, 1, 1, 1, 1000);
    lock_run(1500, "R9");

    // R9: maximum ratio
    scn_start(254, 80, 32, 1, 40, 20000);
    lock_run(30480, "R9");

    chk(n_short > 0, "R4", "shortened symbols observed", n_short, 1);
    chk(n_long > 0, "R5", "lengthened symbols observed", n_long, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule